// File: doc/BRIEF.md
# Key-Chord Hold Reset Detector

This block produces a system reset from a held key chord. It watches four active-high key lines. A static two-bit option picks which of them must be pressed together. When every key in the chosen group stays high long enough, the block asserts its reset output. It does not care whether other keys are also pressed.

The path has three stages. The key lines first pass through a two-flop synchroniser. A noise filter then counts a configurable number of oscillator cycles of continuous chord before it passes the chord on; the default is 49 cycles, about 1.5 ms at 32.768 kHz. The filter counts only while the oscillator-running flag is high. Last, a hold authoriser watches a free-running prescaler tick, which is 1 Hz by default. It fires after a configurable number of ticks, two by default, seen while the filtered chord has stayed high without a break. That gives a hold time between one and two seconds.

The reset output stays high while the chord is held and drops as soon as the synchronised chord falls.

Top module: `chord_reset_detector`

## Requirements
- R1: The option `chord_sel` decodes as follows. 0 is off. 1 needs keys[0] and keys[1]. 2 needs keys[0], keys[1] and keys[2]. 3 needs all of keys[3:0].
- R2: Keys outside the selected group have no effect. Any pattern that covers the group triggers a reset, and any pattern that misses a group key never does.
- R3: The noise filter passes the chord only after FILTER_CYCLES consecutive counted cycles of synchronised chord. A chord that lasts fewer cycles, or a train of such short pulses, never causes a reset.
- R4: While `osc_run` is low, the filter does not advance and the prescaler is halted, so no reset occurs. The filter time is counted only from the point `osc_run` goes high.
- R5: `reset_out` rises only on a prescaler tick. It rises after AUTH_TICKS ticks, counted while the filtered chord is high. With 2^PRESCALE_BITS cycles per tick and the default of two ticks, this takes more than one tick period and at most two tick periods after the filter passes.
- R6: A chord that drops for even one synchronised cycle before authorisation clears the tick count, so the hold starts over and no reset results.
- R7: With `chord_sel` = 0, `reset_out` stays low for every key pattern.
- R8: Once fired, `reset_out` stays high for as long as the chord is held.
- R9: After the chord keys are released, `reset_out` is low within two clock edges.
- R10: While `rst_n` is low, and right after it is released, `reset_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock (32.768 kHz nominal) |
| rst_n | input | 1 | Active-low power-on reset |
| osc_run | input | 1 | High once the oscillator is running |
| keys | input | 4 | Asynchronous active-high key lines |
| chord_sel | input | 2 | Static chord option |
| reset_out | output | 1 | Active-high system reset request |

## Verification
The hardest case to reach from the ports is the phase between the free-running prescaler and the moment the chord filter passes. That phase cannot be observed, so the exact firing cycle cannot be known. The bench therefore runs with a short prescaler and uses hold times that bracket the result for every possible phase. A hold that is too short to contain two ticks must leave the output low, and a hold long enough to contain two ticks must raise it. Short-pulse trains and a single-cycle dropout during the hold test the counters that restart. The bench also sweeps every option against every key pattern.

// File: rtl/chord_reset_pkg.sv
package chord_reset_pkg;
   localparam int KEY_COUNT = 4;

   typedef enum logic [1:0] {
      CHORD_OFF   = 2'd0,
      CHORD_PAIR  = 2'd1,
      CHORD_TRIO  = 2'd2,
      CHORD_QUAD  = 2'd3
   } chord_opt_e;
endpackage

// File: rtl/key_sync.sv
module key_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("key_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= d_async;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else        chain[s] <= chain[s-1];
      end
   end

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/chord_match.sv
module chord_match
   import chord_reset_pkg::*;
(
   input  logic [KEY_COUNT-1:0] keys_s,
   input  chord_opt_e           opt,
   output logic                 hit
);
   logic [KEY_COUNT-1:0] need;
   logic [KEY_COUNT-1:0] ok;

   for (genvar i = 0; i < KEY_COUNT; i++) begin : g_key
      // key 0 and 1 belong to every enabled chord; higher keys join as option grows
      if (i < 2) begin : g_base
         assign need[i] = (opt != CHORD_OFF);
      end else begin : g_ext
         assign need[i] = (opt != CHORD_OFF) && (int'(opt) >= i);
      end
      assign ok[i] = keys_s[i] | ~need[i];
   end

   assign hit = (opt != CHORD_OFF) && (&ok);
endmodule

// File: rtl/chord_noise_filter.sv
module chord_noise_filter #(
   parameter int FILTER_CYCLES = 49
) (
   input  logic clk,
   input  logic rst_n,
   input  logic osc_run,
   input  logic raw,
   output logic clean
);
   localparam int CW = $clog2(FILTER_CYCLES + 1);
   localparam logic [CW-1:0] FULL = CW'(FILTER_CYCLES);

   if (FILTER_CYCLES < 1) begin : g_bad_filter
      $error("chord_noise_filter: FILTER_CYCLES must be positive");
   end

   logic [CW-1:0] run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          run_len <= '0;
      else if (!raw)                       run_len <= '0;
      else if (osc_run && run_len != FULL) run_len <= run_len + 1'b1;
   end

   assign clean = raw && (run_len == FULL);

   assert_clean_needs_history_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clean) |-> $past(raw));

   assert_frozen_without_osc_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!osc_run && !clean) |=> !clean);
endmodule

// File: rtl/hold_authorizer.sv
module hold_authorizer #(
   parameter int PRESCALE_BITS = 15,
   parameter int AUTH_TICKS    = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic osc_run,
   input  logic held,
   output logic fire
);
   localparam int TW = $clog2(AUTH_TICKS + 1);
   localparam logic [TW-1:0] DONE = TW'(AUTH_TICKS);

   if (PRESCALE_BITS < 2) begin : g_bad_pre
      $error("hold_authorizer: PRESCALE_BITS must be at least 2");
   end
   if (AUTH_TICKS < 1) begin : g_bad_ticks
      $error("hold_authorizer: AUTH_TICKS must be positive");
   end

   logic [PRESCALE_BITS-1:0] pre;
   logic                     tick;
   logic [TW-1:0]            seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pre <= '0;
      else if (osc_run) pre <= pre + 1'b1;
   end

   assign tick = osc_run && (&pre);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    seen <= '0;
      else if (!held)                seen <= '0;
      else if (tick && seen != DONE) seen <= seen + 1'b1;
   end

   assign fire = held && (seen == DONE);

   assert_fire_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fire) |-> $past(tick) && $past(held));

   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      seen <= DONE);

   assert_drop_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !held |=> seen == '0);
endmodule

// File: rtl/chord_reset_detector.sv
module chord_reset_detector
   import chord_reset_pkg::*;
#(
   parameter int SYNC_STAGES   = 2,
   parameter int FILTER_CYCLES = 49,
   parameter int PRESCALE_BITS = 15,
   parameter int AUTH_TICKS    = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       osc_run,
   input  logic [3:0] keys,
   input  logic [1:0] chord_sel,
   output logic       reset_out
);
   logic [KEY_COUNT-1:0] keys_s;
   logic                 chord_raw;
   logic                 chord_clean;

   key_sync #(.WIDTH(KEY_COUNT), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (keys),
      .q_sync  (keys_s)
   );

   chord_match u_match (
      .keys_s (keys_s),
      .opt    (chord_opt_e'(chord_sel)),
      .hit    (chord_raw)
   );

   chord_noise_filter #(.FILTER_CYCLES(FILTER_CYCLES)) u_filter (
      .clk     (clk),
      .rst_n   (rst_n),
      .osc_run (osc_run),
      .raw     (chord_raw),
      .clean   (chord_clean)
   );

   hold_authorizer #(.PRESCALE_BITS(PRESCALE_BITS), .AUTH_TICKS(AUTH_TICKS)) u_auth (
      .clk     (clk),
      .rst_n   (rst_n),
      .osc_run (osc_run),
      .held    (chord_clean),
      .fire    (reset_out)
   );

   assert_off_is_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (chord_sel == 2'd0) |-> !reset_out);

   assert_release_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !chord_raw |-> !reset_out);

   assert_stays_while_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(reset_out) && chord_raw && $stable(chord_sel)) |-> reset_out);
endmodule

// File: tb/test_chord_reset_detector.sv
module test_chord_reset_detector;
   localparam int FILT = 4;
   localparam int PB   = 4;
   localparam int TP   = 1 << PB;
   localparam int SYNC = 2;
   localparam int SHORT_HOLD = SYNC + FILT + TP;
   localparam int LONG_HOLD  = SYNC + FILT + 2 * TP + 7;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       osc_run = 1'b0;
   logic [3:0] keys = '0;
   logic [1:0] chord_sel = '0;
   logic       reset_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   chord_reset_detector #(
      .SYNC_STAGES(SYNC), .FILTER_CYCLES(FILT), .PRESCALE_BITS(PB), .AUTH_TICKS(2)
   ) i_chord_reset_detector (
      .clk(clk), .rst_n(rst_n), .osc_run(osc_run),
      .keys(keys), .chord_sel(chord_sel), .reset_out(reset_out)
   );

   task automatic chk(input bit cond, input string req, input int got, input int exp);
      checks++;
      if (!cond) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   // count cycles where reset_out is high over n edges
   task automatic watch(input int n, output int highs);
      highs = 0;
      for (int i = 0; i < n; i++) begin
         edges(1);
         if (reset_out) highs++;
      end
   endtask

   function automatic bit covers(input int sel, input int pat);
      int need;
      need = (sel == 1) ? 4'b0011 : (sel == 2) ? 4'b0111 : (sel == 3) ? 4'b1111 : 0;
      return (sel != 0) && ((pat & need) == need);
   endfunction

   initial begin
      int h;
      #1;
      chk(reset_out == 1'b0, "R10 in reset", reset_out, 0);
      osc_run = 1'b1;
      keys = 4'hF; chord_sel = 2'd3;
      edges(LONG_HOLD);
      chk(reset_out == 1'b0, "R10 held in reset", reset_out, 0);
      keys = '0;
      edges(3);
      rst_n = 1'b1;
      edges(2);
      chk(reset_out == 1'b0, "R10 after release", reset_out, 0);

      // R1 R2 R7: every option against every key pattern
      for (int sel = 0; sel < 4; sel++) begin
         for (int pat = 0; pat < 16; pat++) begin
            chord_sel = sel[1:0];
            keys = pat[3:0];
            edges(LONG_HOLD);
            chk(reset_out == covers(sel, pat),
                (sel == 0) ? "R7 off option" : "R1 R2 chord decode",
                reset_out, covers(sel, pat));
            keys = '0;
            edges(2);
            chk(reset_out == 1'b0, "R9 release", reset_out, 0);
            edges(1);
         end
      end

      // R5 lower bound: hold too short for two ticks
      chord_sel = 2'd2; keys = 4'b0111;
      watch(SHORT_HOLD, h);
      chk(h == 0, "R5 too early", h, 0);
      // R5 upper bound and R8 persistence
      edges(LONG_HOLD - SHORT_HOLD);
      chk(reset_out == 1'b1, "R5 fires by deadline", reset_out, 1);
      watch(50, h);
      chk(h == 50, "R8 stays while held", h, 50);
      keys = 4'b0011;
      edges(2);
      chk(reset_out == 1'b0, "R9 partial release", reset_out, 0);
      keys = '0; edges(3);

      // R3: trains of short pulses never pass the filter
      chord_sel = 2'd1;
      h = 0;
      for (int k = 0; k < 40; k++) begin
         int hh;
         keys = 4'b0011; watch(FILT - 1, hh); h += hh;
         keys = 4'b0000; watch(1, hh); h += hh;
      end
      chk(h == 0, "R3 short pulses", h, 0);

      // R6: one-cycle dropout before authorisation restarts the hold
      keys = 4'b1011;
      watch(SYNC + FILT + TP - 2, h);
      keys = 4'b1001;
      edges(1);
      keys = 4'b1011;
      begin
         int h2;
         watch(SHORT_HOLD, h2);
         h += h2;
      end
      chk(h == 0, "R6 dropout restarts", h, 0);
      edges(2 * TP + 4);
      chk(reset_out == 1'b1, "R6 later full hold", reset_out, 1);
      keys = '0; edges(3);

      // R4: oscillator not running freezes filter and prescaler
      osc_run = 1'b0;
      chord_sel = 2'd3; keys = 4'hF;
      watch(4 * TP, h);
      chk(h == 0, "R4 no osc no reset", h, 0);
      osc_run = 1'b1;
      watch(FILT + TP, h);
      chk(h == 0, "R4 filter counts from osc start", h, 0);
      edges(TP + 6);
      chk(reset_out == 1'b1, "R4 fires after osc start", reset_out, 1);
      keys = '0; edges(2);
      chk(reset_out == 1'b0, "R9 final release", reset_out, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(150000 * 10);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule